// File: doc/BRIEF.md
# Byte-Order Reversal Execution Unit

This unit carries out the byte-order reversal instruction of a general-purpose CPU core with sixteen 64-bit registers. For each instruction the issue logic raises `start` for one cycle. With it, the unit receives the low three bits of the opcode (the register number), the prefix-extension bits, an operand-size override flag and the current operating mode. The unit reads the selected register through its read port, reverses the byte order at the effective operand size, and one cycle later writes the result back through its write port, with `done` raised for that one cycle.

The register file lives outside the unit. The read port is combinational, so the unit presents an index and expects the data in the same cycle. Only the base-extension prefix bit widens the register number, and only in 64-bit mode; the index and reg extension bits play no part. A 16-bit operand size does not swap bytes: it clears the low half-word and keeps bits 31:16. How the bits above the operand are handled depends on the mode. In 64-bit mode they are cleared. In 16-bit and 32-bit mode bits 63:32 are kept. Instructions may be issued back to back: a pending write-back is forwarded to a following instruction that reads the same register.

Top module: `bswap_unit`

## Requirements
- R1: The mode input is encoded 2'b00 = 16-bit, 2'b01 = 32-bit and 2'b10 = 64-bit. The operand size is 64 bits when the mode is 64-bit and the wide bit is set. Otherwise it is 16 bits when (mode is 16-bit) XOR (size override flag), and 32 bits in every other case.
- R2: At 32-bit size the low word is byte-reversed (0x11223344 becomes 0x44332211). In 64-bit mode the written value is this word zero-extended to 64 bits.
- R3: The register index is {base bit AND 64-bit mode, opcode bits 2:0}. The index and reg extension bits never change it. In 64-bit mode with the base bit set, opcode 0 reverses register 8 and leaves register 0 unchanged.
- R4: At 16-bit size, bits 15:0 of the result are zero and bits 31:16 equal the source's bits 31:16. In 64-bit mode 0xFFFFFFFF98765432 becomes 0x0000000098760000.
- R5: In 16-bit and 32-bit mode, bits 63:32 of the written value equal those of the source.
- R6: At 64-bit size all eight bytes are reversed, whatever the size override flag. The wide bit has no effect outside 64-bit mode.
- R7: Each cycle with `start` high causes exactly one write, in the following cycle, and `done` is high in exactly that cycle. Without `start`, no write happens.
- R8: When an instruction starts in the cycle in which the previous one writes the same register, it operates on the value being written.
- R9: While reset is held, `done` and the write enable stay low.
- R10: The 16-bit rule applies to all sixteen registers, including registers 4, 5 and 8 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Issue one instruction this cycle |
| opc_low | input | 3 | Register number from the opcode |
| rex_b | input | 1 | Base-extension prefix bit |
| rex_x | input | 1 | Index-extension prefix bit (no effect) |
| rex_r | input | 1 | Reg-extension prefix bit (no effect) |
| rex_w | input | 1 | Wide-operand prefix bit |
| opsz_pfx | input | 1 | Operand-size override present |
| mode | input | 2 | Operating mode: 00 16-bit, 01 32-bit, 10 64-bit |
| rf_rd_idx | output | 4 | Register file read index |
| rf_rd_data | input | 64 | Register file read data, same cycle |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 4 | Register file write index |
| rf_wr_data | output | 64 | Register file write data |
| done | output | 1 | Instruction complete, one cycle |

## Verification
The assertions assume that `mode` never carries the reserved code 2'b11. They also assume that `rf_rd_data` returns the addressed register's contents in the same cycle as `rf_rd_idx`. The check on preserved upper bits relies on that, and it is switched off when the forwarding path supplies the source. The stimulus uses only the three defined mode codes. The bench plays the register file with a combinational read of a plain array, which it updates only on the unit's write enable. Inputs change only at falling edges, so each value is stable around the rising edge that samples it.

// File: rtl/bswap_pkg.sv
package bswap_pkg;
  localparam int REG_W   = 64;
  localparam int REG_CNT = 16;
  localparam int IDX_W   = $clog2(REG_CNT);
  localparam int OPC_W   = IDX_W - 1;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = REG_W / BYTE_W;
  localparam int HALF_W  = REG_W / 2;
  localparam int QTR_W   = REG_W / 4;

  typedef enum logic [1:0] {
    MODE_16 = 2'b00,
    MODE_32 = 2'b01,
    MODE_64 = 2'b10
  } cpu_mode_e;

  typedef enum logic [1:0] {
    SZ_16 = 2'b00,
    SZ_32 = 2'b01,
    SZ_64 = 2'b10
  } op_size_e;

  typedef logic [REG_W-1:0] reg_t;
  typedef logic [IDX_W-1:0] idx_t;

  // Reverse all bytes of a full register.
  function automatic reg_t rev_full(input reg_t v);
    reg_t r;
    for (int i = 0; i < NBYTES; i++) begin
      r[BYTE_W*i +: BYTE_W] = v[BYTE_W*(NBYTES-1-i) +: BYTE_W];
    end
    return r;
  endfunction

  // Reverse the bytes of the low half of a register.
  function automatic logic [HALF_W-1:0] rev_half(input logic [HALF_W-1:0] v);
    logic [HALF_W-1:0] r;
    for (int i = 0; i < NBYTES/2; i++) begin
      r[BYTE_W*i +: BYTE_W] = v[BYTE_W*(NBYTES/2-1-i) +: BYTE_W];
    end
    return r;
  endfunction

  // Effective operand size from mode, wide bit and size override.
  function automatic op_size_e pick_size(input logic is64, input logic is16m,
                                         input logic wide, input logic ovr);
    if (is64 && wide) return SZ_64;
    if (is16m ^ ovr)  return SZ_16;
    return SZ_32;
  endfunction

  // Final register value: reversal plus upper-bit handling.
  function automatic reg_t compose(input reg_t src, input op_size_e sz, input logic is64);
    reg_t r;
    logic [HALF_W-1:0] upper;
    upper = is64 ? '0 : src[REG_W-1:HALF_W];
    case (sz)
      SZ_64:   r = rev_full(src);
      SZ_16:   r = {upper, src[HALF_W-1:QTR_W], {QTR_W{1'b0}}};
      default: r = {upper, rev_half(src[HALF_W-1:0])};
    endcase
    return r;
  endfunction
endpackage

// File: rtl/bswap_decode.sv
module bswap_decode
  import bswap_pkg::*;
(
  input  logic [OPC_W-1:0] opc_low,
  input  logic             rex_b,
  input  logic             rex_w,
  input  logic             opsz_pfx,
  input  logic [1:0]       mode,
  output idx_t             idx,
  output op_size_e         size,
  output logic             is64
);
  logic is16m;

  always_comb begin
    is64  = (mode == MODE_64);
    is16m = (mode == MODE_16);
    idx   = {is64 & rex_b, opc_low};
    size  = pick_size(is64, is16m, rex_w, opsz_pfx);
  end
endmodule

// File: rtl/bswap_datapath.sv
module bswap_datapath
  import bswap_pkg::*;
(
  input  reg_t     rd_data,
  input  idx_t     idx,
  input  op_size_e size,
  input  logic     is64,
  input  logic     pend_valid,
  input  idx_t     pend_idx,
  input  reg_t     pend_data,
  output logic     fwd_hit,
  output reg_t     result
);
  reg_t src;

  always_comb begin
    fwd_hit = pend_valid && (pend_idx == idx);
    src     = fwd_hit ? pend_data : rd_data;
    result  = compose(src, size, is64);
  end
endmodule

// File: rtl/bswap_wb_stage.sv
module bswap_wb_stage
  import bswap_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  idx_t idx_in,
  input  reg_t data_in,
  output logic we,
  output idx_t idx_q,
  output reg_t data_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we     <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      we <= start;
      if (start) begin
        idx_q  <= idx_in;
        data_q <= data_in;
      end
    end
  end
endmodule

// File: rtl/bswap_unit.sv
module bswap_unit
  import bswap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [OPC_W-1:0]     opc_low,
  input  logic                 rex_b,
  input  logic                 rex_x,
  input  logic                 rex_r,
  input  logic                 rex_w,
  input  logic                 opsz_pfx,
  input  logic [1:0]           mode,
  output logic [IDX_W-1:0]     rf_rd_idx,
  input  logic [REG_W-1:0]     rf_rd_data,
  output logic                 rf_we,
  output logic [IDX_W-1:0]     rf_wr_idx,
  output logic [REG_W-1:0]     rf_wr_data,
  output logic                 done
);
  idx_t     dec_idx;
  op_size_e dec_size;
  logic     dec_is64;
  logic     fwd_hit;
  reg_t     swap_result;
  logic     wb_valid;
  idx_t     wb_idx;
  reg_t     wb_data;

  bswap_decode u_dec (
    .opc_low  (opc_low),
    .rex_b    (rex_b),
    .rex_w    (rex_w),
    .opsz_pfx (opsz_pfx),
    .mode     (mode),
    .idx      (dec_idx),
    .size     (dec_size),
    .is64     (dec_is64)
  );

  bswap_datapath u_dp (
    .rd_data    (rf_rd_data),
    .idx        (dec_idx),
    .size       (dec_size),
    .is64       (dec_is64),
    .pend_valid (wb_valid),
    .pend_idx   (wb_idx),
    .pend_data  (wb_data),
    .fwd_hit    (fwd_hit),
    .result     (swap_result)
  );

  bswap_wb_stage u_wb (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .idx_in  (dec_idx),
    .data_in (swap_result),
    .we      (wb_valid),
    .idx_q   (wb_idx),
    .data_q  (wb_data)
  );

  assign rf_rd_idx  = dec_idx;
  assign rf_we      = wb_valid;
  assign rf_wr_idx  = wb_idx;
  assign rf_wr_data = wb_data;
  assign done       = wb_valid;
endmodule

// File: rtl/bswap_unit_chk.sv
module bswap_unit_chk
  import bswap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [OPC_W-1:0] opc_low,
  input logic             rex_b,
  input logic             rex_x,
  input logic             rex_r,
  input logic             rex_w,
  input logic             opsz_pfx,
  input logic [1:0]       mode,
  input logic [IDX_W-1:0] rf_rd_idx,
  input logic [REG_W-1:0] rf_rd_data,
  input logic             rf_we,
  input logic [IDX_W-1:0] rf_wr_idx,
  input logic [REG_W-1:0] rf_wr_data,
  input logic             done,
  input logic             fwd_hit
);
  logic in64, in16;
  assign in64 = (mode == MODE_64);
  assign in16 = !(in64 && rex_w) && ((mode == MODE_16) ^ opsz_pfx);

  a_r7_done_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (done && rf_we));

  a_r7_no_spurious_write: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && !rf_we));

  // R3: index bits independent of the index/reg extension bits
  a_r3_read_index: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (rf_rd_idx == {in64 && rex_b, opc_low}));

  a_r3_write_index: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (rf_wr_idx == $past(rf_rd_idx)));

  a_r2_zero_extend: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in64 && !rex_w) |=> (rf_wr_data[REG_W-1:HALF_W] == '0));

  a_r4_low_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (start && in16) |=> (rf_wr_data[QTR_W-1:0] == '0));

  a_r5_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !in64 && !fwd_hit) |=>
      (rf_wr_data[REG_W-1:HALF_W] == $past(rf_rd_data[REG_W-1:HALF_W])));

  // R8: forwarding only toward a write pending for the same register
  a_r8_forward_match: assert property (@(posedge clk) disable iff (!rst_n)
    (start && fwd_hit) |-> (rf_we && rf_wr_idx == rf_rd_idx));

  logic unused_ok;
  assign unused_ok = rex_x ^ rex_r;
endmodule

bind bswap_unit bswap_unit_chk u_chk (.*);

// File: tb/sim_bswap_unit.sv
module sim_bswap_unit;
  import bswap_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] opc_low = '0;
  logic rex_b = 0, rex_x = 0, rex_r = 0, rex_w = 0, opsz_pfx = 0;
  logic [1:0] mode = 2'b01;
  logic [3:0] rf_rd_idx, rf_wr_idx;
  logic [63:0] rf_rd_data, rf_wr_data;
  logic rf_we, done;

  logic [63:0] rf [16];
  logic [63:0] model [16];

  typedef struct {
    logic [3:0]  idx;
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  int checks = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bswap_unit u0 (.*);

  assign rf_rd_data = rf[rf_rd_idx];
  always @(posedge clk) if (rf_we) rf[rf_wr_idx] <= rf_wr_data;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_val(input logic [63:0] v, input int bits, input bit m64);
    logic [63:0] r;
    logic [31:0] hi;
    hi = m64 ? 32'h0 : v[63:32];
    if (bits == 64) begin
      for (int k = 0; k < 8; k++) r[63-8*k -: 8] = v[8*k +: 8];
    end else if (bits == 32) begin
      r = {hi, v[7:0], v[15:8], v[23:16], v[31:24]};
    end else begin
      r = {hi, v[31:16], 16'h0000};
    end
    return r;
  endfunction

  // Driver: predicts, pushes to the scoreboard, drives start for one cycle.
  task automatic issue(input logic [2:0] o, input bit b, input bit x, input bit r,
                       input bit w, input bit p, input logic [1:0] md, input string tag);
    bit m64;
    int bits;
    logic [3:0] ix;
    exp_t e;
    m64  = (md == 2'b10);
    ix   = {m64 & b, o};
    bits = (m64 && w) ? 64 : (((md == 2'b00) != p) ? 16 : 32);
    e.idx = ix;
    e.val = ref_val(model[ix], bits, m64);
    e.tag = tag;
    model[ix] = e.val;
    sbq.push_back(e);
    opc_low = o; rex_b = b; rex_x = x; rex_r = r; rex_w = w; opsz_pfx = p; mode = md;
    start = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic preload(input int i, input logic [63:0] v);
    rf[i] = v;
    model[i] = v;
  endtask

  // Monitor: compares every write against the scoreboard head.
  always @(negedge clk) begin
    if (rst_n && rf_we) begin
      if (sbq.size() == 0) begin
        chk(0, "R7 write without start", rf_wr_data, 64'h0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        chk(rf_wr_idx == e.idx, {e.tag, " index"}, 64'(rf_wr_idx), 64'(e.idx));
        chk(rf_wr_data == e.val, {e.tag, " data"}, rf_wr_data, e.val);
      end
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) preload(i, 64'h0101_0101_0000_0000 * i + 64'h1000);
    repeat (3) @(negedge clk);
    chk(done == 0 && rf_we == 0, "R9 reset outputs", 64'(done), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    preload(0, 64'hAAAA_AAAA_1122_3344);
    issue(3'd0, 0, 0, 0, 0, 0, 2'b01, "R1 R5 32-bit mode swap");
    idle();
    chk(done == 0, "R7 single-cycle done", 64'(done), 64'h0);

    preload(0, 64'hFFFF_FFFF_1122_3344);
    issue(3'd0, 0, 0, 0, 0, 0, 2'b10, "R2 zero-extend in 64-bit mode");
    idle();

    preload(0, 64'h0000_0000_5566_7788);
    preload(8, 64'h0000_0000_5566_7788);
    issue(3'd0, 1, 0, 0, 0, 0, 2'b10, "R3 base bit selects reg 8");
    idle();
    preload(8, 64'h0000_0000_5566_7788);
    issue(3'd0, 0, 1, 0, 0, 0, 2'b10, "R3 index bit ignored");
    idle();
    preload(0, 64'h0000_0000_5566_7788);
    issue(3'd0, 0, 0, 1, 0, 0, 2'b10, "R3 reg bit ignored");
    idle();
    issue(3'd3, 1, 0, 0, 0, 0, 2'b01, "R3 base bit ignored outside 64-bit mode");
    idle();

    for (int i = 0; i < 16; i++) begin
      preload(i, 64'hFFFF_FFFF_9876_5432);
      issue(i[2:0], i[3], 0, 0, 0, 1, 2'b10, "R4 R10 16-bit form, 64-bit mode");
      idle();
    end

    preload(4, 64'h1234_5678_9876_5432);
    issue(3'd4, 0, 0, 0, 0, 1, 2'b01, "R5 R10 16-bit form, 32-bit mode");
    idle();
    preload(5, 64'h1234_5678_9876_5432);
    issue(3'd5, 0, 0, 0, 0, 0, 2'b00, "R1 R4 16-bit mode default size");
    idle();
    preload(6, 64'hCAFE_F00D_A1B2_C3D4);
    issue(3'd6, 0, 0, 0, 0, 1, 2'b00, "R1 R5 16-bit mode with override");
    idle();

    preload(9, 64'h0102_0304_0506_0708);
    issue(3'd1, 1, 0, 0, 1, 0, 2'b10, "R6 full reversal");
    idle();
    preload(2, 64'h1122_3344_5566_7788);
    issue(3'd2, 0, 0, 0, 1, 1, 2'b10, "R6 wide beats override");
    idle();
    preload(7, 64'h1122_3344_5566_7788);
    issue(3'd7, 1, 0, 0, 1, 0, 2'b01, "R6 wide ignored outside 64-bit mode");
    idle();

    preload(3, 64'hDEAD_BEEF_0A0B_0C0D);
    issue(3'd3, 0, 0, 0, 0, 0, 2'b10, "R8 back-to-back first");
    issue(3'd3, 0, 0, 0, 0, 0, 2'b10, "R8 back-to-back second");
    issue(3'd3, 0, 0, 0, 1, 0, 2'b10, "R8 back-to-back third");
    issue(3'd1, 0, 0, 0, 0, 1, 2'b01, "R8 back-to-back other reg");
    idle();

    repeat (4) idle();
    chk(sbq.size() == 0, "R7 every start wrote once", 64'(sbq.size()), 64'h0);
    for (int i = 0; i < 16; i++)
      chk(rf[i] == model[i], "R3 R7 final register contents", rf[i], model[i]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule